// File: doc/BRIEF.md
# Vertical Edge Column-Sum Engine

This block measures vertical edge energy inside a rectangular target whose size is chosen per run. Software or an upstream stage loads a height H and a width W and pulses a start. The block then takes a padded window of (H+2) rows by (W+2) columns of 8-bit pixels through a valid/ready stream. Row index is the outer loop and column index the inner loop.

For every interior pixel, two line buffers supply the rows above it. The block forms a horizontal gradient from the columns on either side of the pixel and takes its absolute value. It adds these magnitudes down each column. When the window has been consumed, it streams the W column sums out in column order and then raises a one-cycle done. Sizes can change from run to run. They are held fixed for the whole of a run.

Top module: `vedge_colsum`

## Requirements
- R1: After reset, in_ready, out_valid and done are all low.
- R2: In idle, a start pulse captures cfg_h and cfg_w, which must satisfy 1 <= H <= MAX_H and 1 <= W <= MAX_W. From the next cycle in_ready is high, and it stays high until exactly (H+2)*(W+2) pixels have been accepted. After that it is low.
- R3: Window pixel p[r][c] has r in 0..H+1 and c in 0..W+1. Interior output (j,i), for j in 0..H-1 and i in 0..W-1, has magnitude |(p[j][i+2] + 2*p[j+1][i+2] + p[j+2][i+2]) - (p[j][i] + 2*p[j+1][i] + p[j+2][i])|. The centre column i+1 has no effect.
- R4: After the last pixel, exactly W sums are output, column i carrying the sum over j of the R3 magnitudes, in column order 0 to W-1.
- R5: Every run starts its column sums from zero, so results of an earlier run never leak into a later one.
- R6: While out_valid is high and out_ready is low, out_valid stays high and out_sum stays unchanged.
- R7: done is high for exactly one cycle, in the cycle after the last sum is accepted, and never while out_valid is high.
- R8: A start pulse or a change of cfg_h/cfg_w while a run is in progress has no effect on that run.
- R9: in_ready is low while sums are being output and after done until the next start.
- R10: The extreme sizes work, namely H=1,W=1; H=2,W=MAX_W; and H=MAX_H,W=1. So does the largest magnitude, 1020.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run with the current cfg_h/cfg_w (honoured only when idle) |
| cfg_h | input | $clog2(MAX_H+1) | Target height H |
| cfg_w | input | $clog2(MAX_W+1) | Target width W |
| in_valid | input | 1 | Pixel offered |
| in_ready | output | 1 | Pixel taken when in_valid is also high |
| in_pix | input | 8 | Unsigned pixel value |
| out_valid | output | 1 | Column sum offered |
| out_ready | input | 1 | Downstream takes the column sum |
| out_sum | output | SW | Column sum, wide enough for MAX_H * 1020 |
| done | output | 1 | One-cycle end-of-run pulse |

## Verification
The hardest case to reach from the ports is a start pulse arriving in the middle of a run, together with cfg values that differ from the ones captured. The bench asserts start and shrinks both sizes to 1 in the cycle where half the window has been fed. It then requires the full-size result.

It is also hard to tell a correct centre-column exclusion apart from a wrong kernel. To do that, the bench feeds patterns where only odd columns vary and a step pattern that reaches the largest magnitude. It also runs two targets back to back, so that stale accumulator contents would be visible.

// File: rtl/vecs_pkg.sv
package vecs_pkg;
  parameter int PIX_W = 8;
  parameter int MAG_W = PIX_W + 2;
  parameter int MAG_MAX = 4 * ((1 << PIX_W) - 1);

  // three vertically adjacent pixels of one window column
  typedef struct packed {
    logic [PIX_W-1:0] top;
    logic [PIX_W-1:0] mid;
    logic [PIX_W-1:0] bot;
  } vcol_t;

  typedef enum logic [1:0] {ST_IDLE, ST_FEED, ST_DRAIN} vstate_t;
endpackage

// File: rtl/vecs_linebuf.sv
module vecs_linebuf #(
  parameter int DEPTH = 66,
  parameter int AW    = 7,
  parameter int DW    = 16
) (
  input  logic          clk,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    if (rd_en) rd_data <= mem[rd_addr];
  end
endmodule

// File: rtl/vecs_grad.sv
module vecs_grad
  import vecs_pkg::*;
#(
  parameter int CW = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             vld_i,
  input  vcol_t            right_i,
  input  vcol_t            left_i,
  input  logic [CW-1:0]    col_i,
  input  logic             first_i,
  input  logic             last_i,
  output logic             vld_o,
  output logic [MAG_W-1:0] mag_o,
  output logic [CW-1:0]    col_o,
  output logic             first_o,
  output logic             last_o
);
  logic [MAG_W-1:0] wr_sum, wl_sum;
  logic signed [MAG_W:0] diff;
  logic [MAG_W-1:0] mag;

  // weighted column sums: outer rows x1, middle row x2 (shift)
  always_comb begin
    wr_sum = MAG_W'(right_i.top) + MAG_W'({right_i.mid, 1'b0}) + MAG_W'(right_i.bot);
    wl_sum = MAG_W'(left_i.top)  + MAG_W'({left_i.mid, 1'b0})  + MAG_W'(left_i.bot);
    diff   = $signed({1'b0, wr_sum}) - $signed({1'b0, wl_sum});
    mag    = diff[MAG_W] ? MAG_W'(-diff) : diff[MAG_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_o <= 1'b0;
    end else begin
      vld_o <= vld_i;
    end
    mag_o   <= mag;
    col_o   <= col_i;
    first_o <= first_i;
    last_o  <= last_i;
  end
endmodule

// File: rtl/vecs_colacc.sv
module vecs_colacc
  import vecs_pkg::*;
#(
  parameter int NCOL = 64,
  parameter int CW   = 7,
  parameter int SW   = 16
) (
  input  logic             clk,
  input  logic             upd,
  input  logic [CW-1:0]    col,
  input  logic             first,
  input  logic [MAG_W-1:0] mag,
  input  logic [CW-1:0]    rd_idx,
  output logic [SW-1:0]    rd_sum
);
  logic [SW-1:0] acc [NCOL];

  // first row of a run overwrites: the bank is effectively cleared per run
  always_ff @(posedge clk) begin
    if (upd) acc[col] <= (first ? '0 : acc[col]) + SW'(mag);
  end

  assign rd_sum = acc[rd_idx];
endmodule

// File: rtl/vedge_colsum.sv
module vedge_colsum
  import vecs_pkg::*;
#(
  parameter int MAX_H = 64,
  parameter int MAX_W = 64,
  localparam int HW = $clog2(MAX_H + 1),
  localparam int WW = $clog2(MAX_W + 1),
  localparam int SW = $clog2(MAX_H * MAG_MAX + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [HW-1:0]    cfg_h,
  input  logic [WW-1:0]    cfg_w,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [PIX_W-1:0] in_pix,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [SW-1:0]    out_sum,
  output logic             done
);
  localparam int RW = $clog2(MAX_H + 3);
  localparam int CW = $clog2(MAX_W + 3);
  localparam int LB_DEPTH = MAX_W + 2;

  vstate_t state;
  logic [HW-1:0] h_q;
  logic [WW-1:0] w_q;
  logic [RW-1:0] row_q;
  logic [CW-1:0] col_q;
  logic          feed_open;
  logic          accept;
  logic [RW-1:0] row_last;
  logic [CW-1:0] col_last;

  assign in_ready = (state == ST_FEED) && feed_open;
  assign accept   = in_valid && in_ready;
  assign row_last = RW'(h_q) + RW'(1);
  assign col_last = CW'(w_q) + CW'(1);

  // stage 1: pixel plus the two rows above it from the line buffer
  logic             s1_vld;
  logic [PIX_W-1:0] s1_pix;
  logic [RW-1:0]    s1_row;
  logic [CW-1:0]    s1_col;
  logic [2*PIX_W-1:0] lb_rd;

  vecs_linebuf #(.DEPTH(LB_DEPTH), .AW(CW), .DW(2*PIX_W)) u_lb (
    .clk     (clk),
    .rd_en   (accept),
    .rd_addr (col_q),
    .rd_data (lb_rd),
    .wr_en   (s1_vld),
    .wr_addr (s1_col),
    .wr_data ({s1_pix, lb_rd[2*PIX_W-1:PIX_W]})
  );

  vcol_t cur_col, prev1, prev2;
  assign cur_col = '{top: lb_rd[PIX_W-1:0], mid: lb_rd[2*PIX_W-1:PIX_W], bot: s1_pix};

  logic          g_in_vld, g_in_first, g_in_last;
  logic [CW-1:0] g_in_col;
  assign g_in_vld   = s1_vld && (s1_row >= RW'(2)) && (s1_col >= CW'(2));
  assign g_in_col   = s1_col - CW'(2);
  assign g_in_first = (s1_row == RW'(2));
  assign g_in_last  = (s1_row == row_last) && (s1_col == col_last);

  logic             g_vld, g_first, g_last;
  logic [MAG_W-1:0] g_mag;
  logic [CW-1:0]    g_col;

  vecs_grad #(.CW(CW)) u_grad (
    .clk     (clk),
    .rst     (rst),
    .vld_i   (g_in_vld),
    .right_i (cur_col),
    .left_i  (prev2),
    .col_i   (g_in_col),
    .first_i (g_in_first),
    .last_i  (g_in_last),
    .vld_o   (g_vld),
    .mag_o   (g_mag),
    .col_o   (g_col),
    .first_o (g_first),
    .last_o  (g_last)
  );

  logic [WW-1:0] idx_q;
  logic [SW-1:0] rd_sum;

  vecs_colacc #(.NCOL(MAX_W), .CW(CW), .SW(SW)) u_acc (
    .clk    (clk),
    .upd    (g_vld),
    .col    (g_col),
    .first  (g_first),
    .mag    (g_mag),
    .rd_idx (CW'(idx_q)),
    .rd_sum (rd_sum)
  );

  always_ff @(posedge clk) begin
    s1_pix <= in_pix;
    s1_row <= row_q;
    s1_col <= col_q;
    if (s1_vld) begin
      prev2 <= prev1;
      prev1 <= cur_col;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      h_q       <= '0;
      w_q       <= '0;
      row_q     <= '0;
      col_q     <= '0;
      feed_open <= 1'b0;
      s1_vld    <= 1'b0;
      idx_q     <= '0;
      out_valid <= 1'b0;
      out_sum   <= '0;
      done      <= 1'b0;
    end else begin
      s1_vld <= accept;
      done   <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            h_q       <= cfg_h;
            w_q       <= cfg_w;
            row_q     <= '0;
            col_q     <= '0;
            feed_open <= 1'b1;
            state     <= ST_FEED;
          end
        end
        ST_FEED: begin
          if (accept) begin
            if (col_q == col_last) begin
              col_q <= '0;
              row_q <= row_q + RW'(1);
              if (row_q == row_last) feed_open <= 1'b0;
            end else begin
              col_q <= col_q + CW'(1);
            end
          end
          if (g_vld && g_last) begin
            idx_q <= '0;
            state <= ST_DRAIN;
          end
        end
        default: begin
          if (!out_valid || out_ready) begin
            if (idx_q != w_q) begin
              out_sum   <= rd_sum;
              out_valid <= 1'b1;
              idx_q     <= idx_q + WW'(1);
            end else begin
              out_valid <= 1'b0;
              done      <= 1'b1;
              state     <= ST_IDLE;
            end
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/vedge_colsum_chk.sv
module vedge_colsum_chk #(
  parameter int SW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          in_ready,
  input logic          out_valid,
  input logic          out_ready,
  input logic [SW-1:0] out_sum,
  input logic          done
);
  // R6
  hold_output_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_sum)));

  // R7
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R7
  done_quiet_out_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !out_valid);

  // R9
  no_input_in_drain_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !in_ready);

  // R9
  closed_after_done_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !in_ready);
endmodule

bind vedge_colsum vedge_colsum_chk #(.SW(SW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_sum   (out_sum),
  .done      (done)
);

// File: tb/vedge_colsum_bench.sv
module vedge_colsum_bench;
  localparam int MH = 64;
  localparam int MW = 64;
  localparam int HW = $clog2(MH + 1);
  localparam int WW = $clog2(MW + 1);
  localparam int SW = $clog2(MH * 1020 + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [HW-1:0] cfg_h = '0;
  logic [WW-1:0] cfg_w = '0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [7:0] in_pix = '0;
  logic out_valid;
  logic out_ready = 1'b0;
  logic [SW-1:0] out_sum;
  logic done;

  int checks = 0;
  int errors = 0;

  logic [7:0] img [0:MH+1][0:MW+1];
  int exp_s [0:MW-1];

  always #2 clk = ~clk;

  vedge_colsum #(.MAX_H(MH), .MAX_W(MW)) u_vedge_colsum (
    .clk(clk), .rst(rst), .start(start), .cfg_h(cfg_h), .cfg_w(cfg_w),
    .in_valid(in_valid), .in_ready(in_ready), .in_pix(in_pix),
    .out_valid(out_valid), .out_ready(out_ready), .out_sum(out_sum), .done(done)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
    end
  endtask

  function automatic int absi(input int v);
    return (v < 0) ? -v : v;
  endfunction

  // build window and reference sums from the R3/R4 formula
  task automatic build(input int h, input int w, input int mode, input int seed);
    for (int r = 0; r < h + 2; r++)
      for (int c = 0; c < w + 2; c++) begin
        case (mode)
          1: img[r][c] = (c > (w + 1) / 2) ? 8'd255 : 8'd0;
          2: img[r][c] = (c % 2 == 0) ? 8'd100 : 8'((r * 53 + c * 29 + seed * 7) & 255);
          default: img[r][c] = 8'((r * 37 + c * 91 + seed * 13 + r * c * 5) & 255);
        endcase
      end
    for (int i = 0; i < w; i++) begin
      exp_s[i] = 0;
      for (int j = 0; j < h; j++)
        exp_s[i] += absi((int'(img[j][i+2]) + 2 * int'(img[j+1][i+2]) + int'(img[j+2][i+2]))
                       - (int'(img[j][i]) + 2 * int'(img[j+1][i]) + int'(img[j+2][i])));
    end
  endtask

  task automatic run_case(input string tag, input int h, input int w, input int mode,
                          input int seed, input bit in_gap, input bit out_stall,
                          input bit poke);
    int n, idx, cyc, got, prev_sum;
    bit prev_hold, rdy, poked;
    build(h, w, mode, seed);
    @(negedge clk);
    cfg_h = HW'(h);
    cfg_w = WW'(w);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(in_ready == 1'b1, {tag, " R2 ready after start"}, in_ready, 1);
    n = (h + 2) * (w + 2);
    idx = 0; cyc = 0; poked = 1'b0;
    while (idx < n && cyc < 40000) begin
      if (poke && !poked && idx == n / 2) begin
        start = 1'b1; cfg_h = HW'(1); cfg_w = WW'(1); poked = 1'b1;
      end else begin
        start = 1'b0;
      end
      if (in_gap && (cyc % 3 == 1)) begin
        in_valid = 1'b0;
      end else begin
        in_valid = 1'b1;
        in_pix = img[idx / (w + 2)][idx % (w + 2)];
        if (in_ready) idx++;
      end
      cyc++;
      @(negedge clk);
    end
    start = 1'b0;
    in_valid = 1'b0;
    chk(in_ready == 1'b0, {tag, " R2 closed after window"}, in_ready, 0);
    // collect sums
    got = 0; cyc = 0; prev_hold = 1'b0; prev_sum = 0;
    while (got < w && cyc < 40000) begin
      if (prev_hold) begin
        chk(out_valid == 1'b1 && int'(out_sum) == prev_sum, {tag, " R6 hold"},
            int'(out_sum), prev_sum);
      end
      if (out_valid) chk(in_ready == 1'b0, {tag, " R9 no input in drain"}, in_ready, 0);
      rdy = out_stall ? (cyc % 3 != 0) : 1'b1;
      out_ready = rdy;
      if (out_valid && rdy) begin
        chk(int'(out_sum) == exp_s[got], {tag, " R3 R4 R5 R8 column sum"},
            int'(out_sum), exp_s[got]);
        got++;
      end
      prev_hold = out_valid && !rdy;
      prev_sum = int'(out_sum);
      cyc++;
      @(negedge clk);
    end
    chk(got == w, {tag, " R4 sum count"}, got, w);
    chk(done == 1'b1 && out_valid == 1'b0, {tag, " R7 done after last"}, done, 1);
    chk(in_ready == 1'b0, {tag, " R9 closed at done"}, in_ready, 0);
    @(negedge clk);
    out_ready = 1'b0;
    chk(done == 1'b0, {tag, " R7 done one cycle"}, done, 0);
    chk(in_ready == 1'b0, {tag, " R9 closed until start"}, in_ready, 0);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(in_ready == 1'b0, "R1 in_ready", in_ready, 0);
    chk(out_valid == 1'b0, "R1 out_valid", out_valid, 0);
    chk(done == 1'b0, "R1 done", done, 0);
  endtask

  task automatic t_basic();
    run_case("basic", 4, 5, 0, 1, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_patterns();
    // R10 largest magnitude via step; R3 centre column ignored via odd-column noise
    run_case("step", 3, 6, 1, 0, 1'b0, 1'b0, 1'b0);
    run_case("centre", 5, 7, 2, 3, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_back_to_back();
    // R5 second run must not see first run's sums
    run_case("run_a", 5, 4, 0, 7, 1'b0, 1'b0, 1'b0);
    run_case("run_b", 2, 4, 2, 9, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_stalls();
    run_case("stall", 6, 8, 0, 11, 1'b1, 1'b1, 1'b0);
  endtask

  task automatic t_poke();
    // R8 start and cfg change mid-run ignored
    run_case("poke", 4, 6, 0, 5, 1'b0, 1'b0, 1'b1);
  endtask

  task automatic t_corners();
    run_case("min", 1, 1, 0, 2, 1'b0, 1'b0, 1'b0);
    run_case("widest R10", 2, MW, 0, 4, 1'b0, 1'b1, 1'b0);
    run_case("tallest R10", MH, 1, 2, 6, 1'b1, 1'b0, 1'b0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_basic();
    t_patterns();
    t_back_to_back();
    t_stalls();
    t_poke();
    t_corners();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule